// File: doc/BRIEF.md
# Double-Pulse Phase Mapper for Zero Common-Mode Modulation

The mapper sits between the duty computation and the pulse generator of a three-phase multilevel modulator that keeps the common-mode voltage at zero. Each carrier cycle, one phase must switch twice (the double-pulse, or d, sequence). The other two phases switch once each, one on the first single-pulse sequence (s1) and one on the second (s2). The choice of the double-pulse phase sets the output current ripple. The lowest ripple comes from giving the double pulse to the phase with the largest active component in the pattern whose three switching states hold two ones. In the pattern whose states hold a single one, it goes to the phase with the smallest active component.

On every load strobe the block takes the three active components, the pattern flag and the present switch state of each phase. It picks the double-pulse phase. When that phase differs from the one held, the block also assigns s1 and s2 to the remaining phases, so that as few extra commutations as possible occur at the region boundary. When the double-pulse phase is unchanged, the held assignment is kept. The result is registered and appears one clock after the strobe, flagged by `map_valid`.

The s1 sequence begins a carrier cycle in state 0 and the s2 sequence begins in state 1. A phase whose present state matches the starting level of its new sequence therefore needs no extra transition.

Top module: `double_pulse_mapper`

## Requirements
- R1: When the load strobe is high and `pattern_min` is 0, the phase with the largest active component becomes the double-pulse phase.
- R2: When the load strobe is high and `pattern_min` is 1, the phase with the smallest active component becomes the double-pulse phase.
- R3: Equal components in the largest or smallest comparison go to the phase that comes first in the order A, B, C.
- R4: On a change of double-pulse phase where the two other phases have different present switch states, the phase in state 1 gets s2 and the phase in state 0 gets s1. Switch state bit 0 is phase A, bit 1 is phase B, bit 2 is phase C.
- R5: On a change of double-pulse phase where the two other phases have equal switch states, the previous double-pulse phase gets s2 if its state is 1 and s1 if its state is 0, and the remaining phase gets the other sequence.
- R6: When a load selects the same double-pulse phase as the one held, the s1 and s2 assignments are unchanged.
- R7: After reset, phase A holds the double pulse, phase B holds s1 and phase C holds s2.
- R8: The three select outputs are each one-hot (bit 0 = A, bit 1 = B, bit 2 = C) and together cover all three phases without overlap.
- R9: A new mapping appears on the outputs one clock after a load strobe, with `map_valid` high for that one cycle. Without a strobe, the outputs keep their values and `map_valid` stays low, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Carrier-cycle strobe; samples the inputs below |
| pattern_min | input | 1 | 0: two-ones pattern (largest wins), 1: single-one pattern (smallest wins) |
| duty_a | input | DUTY_W | Active component of phase A |
| duty_b | input | DUTY_W | Active component of phase B |
| duty_c | input | DUTY_W | Active component of phase C |
| sw_state | input | 3 | Present switch state per phase (bit 0 = A) |
| map_valid | output | 1 | High one cycle after a load |
| dbl_sel | output | 3 | One-hot double-pulse phase |
| s1_sel | output | 3 | One-hot phase on the s1 sequence |
| s2_sel | output | 3 | One-hot phase on the s2 sequence |

## Verification
The bench builds the block with `DUTY_W` set to 6, so that only 64 component values exist. With so few values, ties between two or three phases turn up often in the random phase and not only in the directed ones. This exercises the A-B-C priority under both patterns. Random switch states, together with frequent changes of the winning phase, reach both the differing-state case and the equal-state case of the boundary assignment from every previous double-pulse phase.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

   localparam int NUM_PH = 3;

   typedef logic [1:0] ph_idx_t;

   localparam ph_idx_t PH_A = 2'd0;
   localparam ph_idx_t PH_B = 2'd1;
   localparam ph_idx_t PH_C = 2'd2;

   // Next phase in the cyclic order A -> B -> C -> A
   function automatic ph_idx_t ph_next(input ph_idx_t i);
      return (i == PH_C) ? PH_A : ph_idx_t'(i + 2'd1);
   endfunction

   function automatic logic [NUM_PH-1:0] ph_onehot(input ph_idx_t i);
      logic [NUM_PH-1:0] v;
      v = '0;
      for (int k = 0; k < NUM_PH; k++) begin
         if (ph_idx_t'(k) == i) v[k] = 1'b1;
      end
      return v;
   endfunction

endpackage

// File: rtl/dpm_select.sv
// Picks the double-pulse phase: largest component or smallest component,
// ties resolved towards the lowest phase index.
module dpm_select
   import dpm_pkg::*;
#(
   parameter int DUTY_W = 12
) (
   input  logic                     pattern_min,
   input  logic [NUM_PH*DUTY_W-1:0] duty_flat,
   output ph_idx_t                  win_ph
);

   logic [DUTY_W-1:0] key [NUM_PH];
   logic [NUM_PH-1:0] beats_all;

   // Smallest-wins is turned into largest-wins by inverting the key,
   // which preserves equality and therefore the tie order.
   for (genvar i = 0; i < NUM_PH; i++) begin : g_key
      assign key[i] = pattern_min ? ~duty_flat[i*DUTY_W +: DUTY_W]
                                  :  duty_flat[i*DUTY_W +: DUTY_W];
   end

   // Phase i wins when it is strictly above every earlier phase and at
   // least equal to every later phase: exactly one phase satisfies this.
   for (genvar i = 0; i < NUM_PH; i++) begin : g_beat
      always_comb begin
         beats_all[i] = 1'b1;
         for (int j = 0; j < NUM_PH; j++) begin
            if (j < i) begin
               beats_all[i] = beats_all[i] & (key[i] >  key[j]);
            end else if (j > i) begin
               beats_all[i] = beats_all[i] & (key[i] >= key[j]);
            end
         end
      end
   end

   always_comb begin
      win_ph = PH_C;
      for (int i = NUM_PH - 1; i >= 0; i--) begin
         if (beats_all[i]) win_ph = ph_idx_t'(i);
      end
   end

endmodule

// File: rtl/dpm_assign.sv
// Single-pulse sequence assignment for a change of double-pulse phase.
// s1 begins a carrier cycle low, s2 begins high.
module dpm_assign
   import dpm_pkg::*;
(
   input  ph_idx_t           new_dbl,
   input  ph_idx_t           old_dbl,
   input  logic [NUM_PH-1:0] sw_state,
   output ph_idx_t           s1_ph,
   output ph_idx_t           s2_ph
);

   ph_idx_t ph_p;
   ph_idx_t ph_q;
   ph_idx_t keep_ph;
   ph_idx_t other_ph;
   logic    st_p;
   logic    st_q;
   logic    st_keep;

   assign ph_p = ph_next(new_dbl);
   assign ph_q = ph_next(ph_p);

   always_comb begin
      st_p = 1'b0;
      st_q = 1'b0;
      st_keep = 1'b0;
      for (int k = 0; k < NUM_PH; k++) begin
         if (ph_idx_t'(k) == ph_p) st_p = sw_state[k];
         if (ph_idx_t'(k) == ph_q) st_q = sw_state[k];
      end
      // The previously doubled phase is the one spared a commutation
      keep_ph  = (old_dbl == ph_q) ? ph_q : ph_p;
      other_ph = (keep_ph == ph_p) ? ph_q : ph_p;
      for (int k = 0; k < NUM_PH; k++) begin
         if (ph_idx_t'(k) == keep_ph) st_keep = sw_state[k];
      end
   end

   always_comb begin
      if (st_p != st_q) begin
         if (st_p) begin
            s2_ph = ph_p;
            s1_ph = ph_q;
         end else begin
            s1_ph = ph_p;
            s2_ph = ph_q;
         end
      end else if (st_keep) begin
         s2_ph = keep_ph;
         s1_ph = other_ph;
      end else begin
         s1_ph = keep_ph;
         s2_ph = other_ph;
      end
   end

endmodule

// File: rtl/dpm_state.sv
// Holds the current mapping; updates the single-pulse pair only on a
// change of double-pulse phase.
module dpm_state
   import dpm_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    load,
   input  ph_idx_t win_ph,
   input  ph_idx_t s1_next,
   input  ph_idx_t s2_next,
   output ph_idx_t dbl_q,
   output ph_idx_t s1_q,
   output ph_idx_t s2_q,
   output logic    valid_q
);

   logic region_change;

   assign region_change = load && (win_ph != dbl_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dbl_q   <= PH_A;
         s1_q    <= PH_B;
         s2_q    <= PH_C;
         valid_q <= 1'b0;
      end else begin
         valid_q <= load;
         if (region_change) begin
            dbl_q <= win_ph;
            s1_q  <= s1_next;
            s2_q  <= s2_next;
         end
      end
   end

endmodule

// File: rtl/double_pulse_mapper.sv
module double_pulse_mapper
   import dpm_pkg::*;
#(
   parameter int DUTY_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              pattern_min,
   input  logic [DUTY_W-1:0] duty_a,
   input  logic [DUTY_W-1:0] duty_b,
   input  logic [DUTY_W-1:0] duty_c,
   input  logic [2:0]        sw_state,
   output logic              map_valid,
   output logic [2:0]        dbl_sel,
   output logic [2:0]        s1_sel,
   output logic [2:0]        s2_sel
);

   localparam int FLAT_W = NUM_PH * DUTY_W;

   if (DUTY_W < 2 || DUTY_W > 32) begin : g_bad_width
      $error("double_pulse_mapper: DUTY_W must lie in 2..32");
   end

   logic [FLAT_W-1:0] duty_flat;
   ph_idx_t           win_ph;
   ph_idx_t           s1_next;
   ph_idx_t           s2_next;
   ph_idx_t           dbl_q;
   ph_idx_t           s1_q;
   ph_idx_t           s2_q;

   assign duty_flat = {duty_c, duty_b, duty_a};

   dpm_select #(.DUTY_W(DUTY_W)) u_select (
      .pattern_min (pattern_min),
      .duty_flat   (duty_flat),
      .win_ph      (win_ph)
   );

   dpm_assign u_assign (
      .new_dbl  (win_ph),
      .old_dbl  (dbl_q),
      .sw_state (sw_state),
      .s1_ph    (s1_next),
      .s2_ph    (s2_next)
   );

   dpm_state u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .win_ph  (win_ph),
      .s1_next (s1_next),
      .s2_next (s2_next),
      .dbl_q   (dbl_q),
      .s1_q    (s1_q),
      .s2_q    (s2_q),
      .valid_q (map_valid)
   );

   assign dbl_sel = ph_onehot(dbl_q);
   assign s1_sel  = ph_onehot(s1_q);
   assign s2_sel  = ph_onehot(s2_q);

endmodule

// File: rtl/dpm_checker.sv
module dpm_checker #(
   parameter int DUTY_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load,
   input logic              pattern_min,
   input logic [DUTY_W-1:0] duty_a,
   input logic [DUTY_W-1:0] duty_b,
   input logic [DUTY_W-1:0] duty_c,
   input logic [2:0]        sw_state,
   input logic              map_valid,
   input logic [2:0]        dbl_sel,
   input logic [2:0]        s1_sel,
   input logic [2:0]        s2_sel
);

   // Inputs and outputs captured at the strobe
   logic [DUTY_W-1:0] cap_a, cap_b, cap_c;
   logic              cap_min;
   logic [2:0]        cap_sw, cap_dbl, cap_s1, cap_s2;
   logic [DUTY_W-1:0] sel_duty;
   logic              tie_earlier;
   logic              changed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_a <= '0; cap_b <= '0; cap_c <= '0;
         cap_min <= 1'b0; cap_sw <= '0;
         cap_dbl <= 3'b001; cap_s1 <= 3'b010; cap_s2 <= 3'b100;
      end else if (load) begin
         cap_a <= duty_a; cap_b <= duty_b; cap_c <= duty_c;
         cap_min <= pattern_min; cap_sw <= sw_state;
         cap_dbl <= dbl_sel; cap_s1 <= s1_sel; cap_s2 <= s2_sel;
      end
   end

   always_comb begin
      sel_duty = dbl_sel[0] ? cap_a : (dbl_sel[1] ? cap_b : cap_c);
      tie_earlier = (dbl_sel[1] && cap_a == sel_duty) ||
                    (dbl_sel[2] && (cap_a == sel_duty || cap_b == sel_duty));
      changed = (dbl_sel != cap_dbl);
   end

   assert_largest_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (map_valid && !cap_min) |->
         (sel_duty >= cap_a && sel_duty >= cap_b && sel_duty >= cap_c));

   assert_smallest_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (map_valid && cap_min) |->
         (sel_duty <= cap_a && sel_duty <= cap_b && sel_duty <= cap_c));

   assert_tie_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      map_valid |-> !tie_earlier);

   assert_split_states_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (map_valid && changed && $countones(cap_sw & ~dbl_sel) == 1) |->
         (((s2_sel & ~cap_sw) == 3'b000) && ((s1_sel & cap_sw) == 3'b000)));

   assert_equal_states_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (map_valid && changed && $countones(cap_sw & ~dbl_sel) != 1) |->
         ((cap_dbl & ((|(cap_sw & cap_dbl)) ? s2_sel : s1_sel)) != 3'b000));

   assert_same_region_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (map_valid && !changed) |-> (s1_sel == cap_s1 && s2_sel == cap_s2));

   assert_onehot_cover_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(dbl_sel) == 1 && $countones(s1_sel) == 1 &&
       $countones(s2_sel) == 1 && (dbl_sel | s1_sel | s2_sel) == 3'b111));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (!map_valid && $stable(dbl_sel) && $stable(s1_sel) &&
                 $stable(s2_sel)));

endmodule

bind double_pulse_mapper dpm_checker #(.DUTY_W(DUTY_W)) u_dpm_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .load        (load),
   .pattern_min (pattern_min),
   .duty_a      (duty_a),
   .duty_b      (duty_b),
   .duty_c      (duty_c),
   .sw_state    (sw_state),
   .map_valid   (map_valid),
   .dbl_sel     (dbl_sel),
   .s1_sel      (s1_sel),
   .s2_sel      (s2_sel)
);

// File: tb/test_double_pulse_mapper.sv
`timescale 1ns/1ps
module test_double_pulse_mapper;

   localparam int W = 6;

   typedef struct {
      logic [2:0] d;
      logic [2:0] s1;
      logic [2:0] s2;
      string      tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         load = 1'b0;
   logic         pattern_min = 1'b0;
   logic [W-1:0] duty_a = '0, duty_b = '0, duty_c = '0;
   logic [2:0]   sw_state = '0;
   logic         map_valid;
   logic [2:0]   dbl_sel, s1_sel, s2_sel;

   int   errors = 0;
   int   checks = 0;
   bit   done = 1'b0;
   exp_t sb[$];

   // model state as phase indices 0=A 1=B 2=C
   int m_d = 0, m_s1 = 1, m_s2 = 2;

   always #5 clk = ~clk;

   double_pulse_mapper #(.DUTY_W(W)) i_double_pulse_mapper (
      .clk(clk), .rst_n(rst_n), .load(load), .pattern_min(pattern_min),
      .duty_a(duty_a), .duty_b(duty_b), .duty_c(duty_c), .sw_state(sw_state),
      .map_valid(map_valid), .dbl_sel(dbl_sel), .s1_sel(s1_sel), .s2_sel(s2_sel)
   );

   function automatic logic [2:0] oh(input int i);
      return 3'b001 << i;
   endfunction

   task automatic check3(input string tag, input logic [2:0] act, input logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // Reference from the requirements (R1, R2, R3, R4, R5, R6)
   task automatic model(input logic pm, input int a, input int b, input int c,
                        input logic [2:0] sw);
      int v[3];
      int w, p, q, keep, oth;
      v[0] = a; v[1] = b; v[2] = c;
      w = 0;
      for (int k = 1; k < 3; k++) begin
         if (!pm && v[k] > v[w]) w = k;   // R1 largest, R3 earlier wins ties
         if ( pm && v[k] < v[w]) w = k;   // R2 smallest
      end
      if (w != m_d) begin
         p = (w + 1) % 3;
         q = (w + 2) % 3;
         if (sw[p] != sw[q]) begin        // R4
            m_s2 = sw[p] ? p : q;
            m_s1 = sw[p] ? q : p;
         end else begin                   // R5
            keep = m_d;
            oth  = (keep == p) ? q : p;
            m_s2 = sw[keep] ? keep : oth;
            m_s1 = sw[keep] ? oth : keep;
         end
         m_d = w;
      end                                 // else R6: pair kept
   endtask

   task automatic drive(input logic pm, input int a, input int b, input int c,
                        input logic [2:0] sw, input string tag);
      exp_t e;
      @(negedge clk);
      pattern_min = pm;
      duty_a = W'(a); duty_b = W'(b); duty_c = W'(c);
      sw_state = sw;
      load = 1'b1;
      model(pm, a, b, c, sw);
      e.d = oh(m_d); e.s1 = oh(m_s1); e.s2 = oh(m_s2); e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      load = 1'b0;
   endtask

   // Monitor: pops one expected item per map_valid pulse (R9 timing)
   always @(negedge clk) begin
      if (rst_n && map_valid) begin
         exp_t e;
         if (sb.size() == 0) begin
            checks++; errors++;
            $display("FAIL R9: map_valid with nothing expected, actual=1 expected=0");
         end else begin
            e = sb.pop_front();
            check3({e.tag, " dbl"}, dbl_sel, e.d);
            check3({e.tag, " s1"},  s1_sel,  e.s1);
            check3({e.tag, " s2"},  s2_sel,  e.s2);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R7: reset mapping
      check3("R7 reset dbl", dbl_sel, 3'b001);
      check3("R7 reset s1",  s1_sel,  3'b010);
      check3("R7 reset s2",  s2_sel,  3'b100);
      rst_n = 1'b1;
      @(negedge clk);
      check3("R9 idle valid", {2'b00, map_valid}, 3'b000);

      drive(1'b0, 10, 40, 5,  3'b001, "R1 largest B, R4 split");   // B; A=1->s2, C->s1
      drive(1'b0, 11, 50, 30, 3'b110, "R6 same region");          // B again, keep
      drive(1'b1, 3,  60, 20, 3'b110, "R2 smallest A, R5 ones");  // A; B,C=1; old B->s2
      drive(1'b0, 1,  63, 63, 3'b000, "R3 tie B over C");         // B; A,C=0; old A->s1
      drive(1'b1, 7,  7,  7,  3'b000, "R3 tie A first");          // A; old B, state 0->s1
      drive(1'b1, 9,  8,  2,  3'b010, "R2 smallest C, R4 split"); // C; A0,B1 -> B s2
      drive(1'b0, 63, 63, 63, 3'b101, "R3 all equal max");        // A

      // R9: inputs move without a strobe; outputs must hold
      @(negedge clk);
      pattern_min = 1'b1; duty_a = 6'd0; duty_b = 6'd63; duty_c = 6'd63; sw_state = 3'b111;
      repeat (4) @(negedge clk);
      check3("R9 hold dbl", dbl_sel, oh(m_d));
      check3("R9 hold s1",  s1_sel,  oh(m_s1));
      check3("R9 hold s2",  s2_sel,  oh(m_s2));
      check3("R9 hold valid", {2'b00, map_valid}, 3'b000);

      for (int n = 0; n < 400; n++) begin
         drive(1'($urandom_range(0, 1)), int'($urandom_range(0, 63)),
               int'($urandom_range(0, 63)), int'($urandom_range(0, 63)),
               3'($urandom_range(0, 7)), "R8 random");
      end
      repeat (3) @(negedge clk);
      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL R9: results missing, actual=%0d expected=0", sb.size());
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule